// File: doc/BRIEF.md
# Bus Responder Collision Guard

This block watches the per-slot "claim" lines of an expansion bus. A card raises its claim line whenever it decodes an address as its own. While the address strobe is asserted, the guard counts the claim lines that can take part in detection. If two or more are active at once, it raises a bus error. In the same cycle it raises a global driver-disable, which every card uses to release its bus drivers. This keeps cards and bus buffers out of a drive fight. The tri-state buffers themselves sit outside this block.

One slot position can be marked as the coprocessor slot. That slot has no claim line of its own. Its bit in the claim vector is tied out of detection when the block is built, so a response from that slot can never add to the count. The error is held for as long as the address strobe stays asserted. It clears one clock after the strobe is seen negated. A detection style parameter picks one of two implementations of the "two or more" test: a population-count adder, or a saturating two-flag scan. Both give the same result.

Top module: `bus_collision_guard`

## Requirements
- R1: While rst_n is low, bus_err and drv_off are both 0, whatever addr_strobe and claim do.
- R2: If addr_strobe is 1 at a rising clock edge and two or more claim bits other than the excluded bit are 1, then bus_err is 1 after that edge.
- R3: drv_off carries the same value as bus_err in every cycle.
- R4: With addr_strobe at 1, a claim vector that has none or exactly one counted bit set never raises bus_err.
- R5: While addr_strobe is 0, the claim lines are ignored: any claim pattern leaves bus_err at 0.
- R6: Once bus_err is 1, it stays 1 at every edge where addr_strobe is still 1, even if every claim line has dropped.
- R7: The first rising edge that samples addr_strobe at 0 clears bus_err and drv_off to 0.
- R8: Claim bit COPRO_SLOT (bit 0 by default) is excluded from detection. That bit together with exactly one other claim bit does not raise bus_err.
- R9: All NUM_SLOTS claim bits set while addr_strobe is 1 raises bus_err at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_strobe | input | 1 | High while a valid address phase is on the bus |
| claim | input | NUM_SLOTS | Per-slot claim lines, high when a card decodes the address as its own |
| bus_err | output | 1 | Collision bus error, registered |
| drv_off | output | 1 | Global command for all cards to release their bus drivers |

## Verification
Setting an error and clearing it can fall on the same edge. When the strobe drops while several claim lines are still high, the clear wins. When the strobe rises with a collision already present, detection wins and starts a fresh error straight away. The bench provokes both: it drops the strobe under a full claim vector, and it raises the strobe for single cycles over every claim pattern. A behavioural reference model, updated at every edge, judges the outcome, and each result is compared on the falling edge that follows.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;

   // implementation choice for the "two or more responders" test
   typedef enum logic {
      DET_POPCOUNT = 1'b0,
      DET_SCAN     = 1'b1
   } det_mode_e;

   // state of the trip latch
   typedef enum logic {
      GUARD_QUIET = 1'b0,
      GUARD_TRIP  = 1'b1
   } guard_state_e;

   // bit width able to hold a count of 0..n
   function automatic int count_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/bcg_claim_mask.sv
`timescale 1ns/1ps
// Removes the slot that cannot take part in detection from the claim vector.
module bcg_claim_mask #(
   parameter int NUM_SLOTS  = 5,
   parameter bit HAS_COPRO  = 1'b1,
   parameter int COPRO_SLOT = 0
) (
   input  logic [NUM_SLOTS-1:0] claim_in,
   output logic [NUM_SLOTS-1:0] claim_live
);

   for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_bit
      localparam bit KEEP = !(HAS_COPRO && (gi == COPRO_SLOT));
      if (KEEP) begin : g_pass
         assign claim_live[gi] = claim_in[gi];
      end else begin : g_block
         assign claim_live[gi] = claim_in[gi] & 1'b0;
      end
   end

endmodule

// File: rtl/bcg_multi_detect.sv
`timescale 1ns/1ps
// Flags two or more active bits in the live claim vector.
module bcg_multi_detect
   import bcg_pkg::*;
#(
   parameter int        NUM_SLOTS = 5,
   parameter det_mode_e MODE      = DET_POPCOUNT
) (
   input  logic [NUM_SLOTS-1:0] claim_live,
   output logic                 multi
);

   localparam int CW = count_width(NUM_SLOTS);

   if (MODE == DET_POPCOUNT) begin : g_popcount
      logic [CW-1:0] tally;
      always_comb begin
         tally = '0;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            tally = tally + CW'(claim_live[i]);
         end
      end
      assign multi = (tally >= CW'(2));
   end else begin : g_scan
      logic seen_one;
      logic seen_two;
      always_comb begin
         seen_one = 1'b0;
         seen_two = 1'b0;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            seen_two = seen_two | (seen_one & claim_live[i]);
            seen_one = seen_one | claim_live[i];
         end
      end
      assign multi = seen_two;
   end

endmodule

// File: rtl/bcg_trip_latch.sv
`timescale 1ns/1ps
// Holds the collision error for the rest of the address phase.
module bcg_trip_latch
   import bcg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic multi,
   output logic trip,
   output logic kill
);

   guard_state_e state_q, state_d;
   logic         kill_q;

   always_comb begin
      state_d = state_q;
      if (!strobe) begin
         state_d = GUARD_QUIET;
      end else if (multi) begin
         state_d = GUARD_TRIP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GUARD_QUIET;
         kill_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         kill_q  <= (state_d == GUARD_TRIP);
      end
   end

   assign trip = (state_q == GUARD_TRIP);
   assign kill = kill_q;

endmodule

// File: rtl/bus_collision_guard.sv
`timescale 1ns/1ps
module bus_collision_guard
   import bcg_pkg::*;
#(
   parameter int        NUM_SLOTS  = 5,
   parameter bit        HAS_COPRO  = 1'b1,
   parameter int        COPRO_SLOT = 0,
   parameter det_mode_e DET_MODE   = DET_POPCOUNT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_strobe,
   input  logic [NUM_SLOTS-1:0] claim,
   output logic                 bus_err,
   output logic                 drv_off
);

   // elaboration-time parameter checks
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("bus_collision_guard: NUM_SLOTS must be at least 2");
   end
   if (HAS_COPRO && (COPRO_SLOT < 0 || COPRO_SLOT >= NUM_SLOTS)) begin : g_bad_copro
      $error("bus_collision_guard: COPRO_SLOT out of range");
   end

   logic [NUM_SLOTS-1:0] claim_live;
   logic                 multi;

   bcg_claim_mask #(
      .NUM_SLOTS (NUM_SLOTS),
      .HAS_COPRO (HAS_COPRO),
      .COPRO_SLOT(COPRO_SLOT)
   ) u_mask (
      .claim_in  (claim),
      .claim_live(claim_live)
   );

   bcg_multi_detect #(
      .NUM_SLOTS(NUM_SLOTS),
      .MODE     (DET_MODE)
   ) u_detect (
      .claim_live(claim_live),
      .multi     (multi)
   );

   bcg_trip_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(addr_strobe),
      .multi (multi),
      .trip  (bus_err),
      .kill  (drv_off)
   );

endmodule

// File: rtl/bcg_guard_chk.sv
`timescale 1ns/1ps
module bcg_guard_chk #(
   parameter int NUM_SLOTS  = 5,
   parameter bit HAS_COPRO  = 1'b1,
   parameter int COPRO_SLOT = 0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 addr_strobe,
   input logic [NUM_SLOTS-1:0] claim,
   input logic                 bus_err,
   input logic                 drv_off
);

   logic [NUM_SLOTS-1:0] counted;
   always_comb begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
         counted[i] = claim[i] && !(HAS_COPRO && (i == COPRO_SLOT));
      end
   end

   // R2
   collide_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_strobe && $countones(counted) >= 2) |=> bus_err);

   // R3
   kill_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err == drv_off);

   // R4
   quiet_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_err && !(addr_strobe && $countones(counted) >= 2)) |=> !bus_err);

   // R5
   strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_strobe && !bus_err) |=> !bus_err);

   // R6
   trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && addr_strobe) |=> bus_err);

   // R7
   trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_strobe |=> (!bus_err && !drv_off));

endmodule

bind bus_collision_guard bcg_guard_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .HAS_COPRO (HAS_COPRO),
   .COPRO_SLOT(COPRO_SLOT)
) u_guard_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_strobe(addr_strobe),
   .claim      (claim),
   .bus_err    (bus_err),
   .drv_off    (drv_off)
);

// File: tb/bus_collision_guard_bench.sv
`timescale 1ns/1ps
module bus_collision_guard_bench;

   localparam int N     = 5;
   localparam int COPRO = 0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         addr_strobe = 1'b0;
   logic [N-1:0] claim = '0;
   logic         bus_err;
   logic         drv_off;

   int   checks = 0;
   int   errors = 0;
   logic ref_err = 1'b0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   bus_collision_guard #(
      .NUM_SLOTS (N),
      .HAS_COPRO (1'b1),
      .COPRO_SLOT(COPRO)
   ) u_bus_collision_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_strobe(addr_strobe),
      .claim      (claim),
      .bus_err    (bus_err),
      .drv_off    (drv_off)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(input logic stb, input logic [N-1:0] cl, input string tag);
      int n;
      addr_strobe = stb;
      claim       = cl;
      @(posedge clk);
      n = 0;
      for (int i = 0; i < N; i++) begin
         if (i != COPRO && cl[i]) n++;
      end
      if (!stb) ref_err = 1'b0;
      else if (n >= 2) ref_err = 1'b1;
      @(negedge clk);
      check(bus_err, ref_err, tag);
      check(drv_off, ref_err, {tag, " drv_off R3"});
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset dominates hostile inputs
      addr_strobe = 1'b1;
      claim       = '1;
      repeat (3) begin
         @(negedge clk);
         check(bus_err, 1'b0, "R1 reset bus_err");
         check(drv_off, 1'b0, "R1 reset drv_off");
      end
      addr_strobe = 1'b0;
      claim       = '0;
      rst_n       = 1'b1;
      ref_err     = 1'b0;
      @(negedge clk);

      // R5: claims ignored without strobe
      step(1'b0, 5'b00110, "R5 collision pattern, strobe low");
      step(1'b0, 5'b11111, "R5 all claims, strobe low");
      // R4: none or one claim
      step(1'b1, 5'b00000, "R4 no claim");
      step(1'b1, 5'b00010, "R4 one claim");
      step(1'b1, 5'b10000, "R4 one claim top slot");
      // R8: coprocessor bit plus one other
      step(1'b1, 5'b00101, "R8 copro plus slot2");
      step(1'b1, 5'b00001, "R8 copro alone");
      // R2: collision
      step(1'b1, 5'b00110, "R2 two claims");
      // R6: hold after claims drop
      step(1'b1, 5'b00000, "R6 hold, claims dropped");
      step(1'b1, 5'b00010, "R6 hold, one claim");
      // R7: clear when strobe drops
      step(1'b0, 5'b00000, "R7 clear");
      step(1'b0, 5'b00000, "R7 stays clear");
      // R9: all slots
      step(1'b1, 5'b11111, "R9 all claims");
      // R7 + R5: clear wins with full claim vector present
      step(1'b0, 5'b11111, "R7 clear under full claims");
      // set on the same edge strobe rises
      step(1'b1, 5'b11000, "R2 collision on strobe rise");
      step(1'b0, 5'b11000, "R7 clear again");

      // every claim pattern for one strobe cycle, then a gap
      for (int p = 0; p < (1 << N); p++) begin
         step(1'b1, N'(p), "R2/R4/R8 sweep strobe high");
         step(1'b0, N'(p), "R5/R7 sweep strobe low");
      end
      // back-to-back strobe cycles, held error across changing claims
      for (int p = 0; p < (1 << N); p++) begin
         step(1'b1, N'(p), "R6 sweep continuous strobe");
      end
      step(1'b0, 5'b00000, "R7 final clear");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule